// File: doc/BRIEF.md
# Covert-Write Unlock and Command Controller for a Read-Only Flash Socket

This block sits behind a read-only option ROM socket on a CPU bus whose low address and data share eight pins. The host has no write strobe to use, so it sends data by reading from addresses whose low byte carries the payload. The controller runs only on the falling edge of the address latch enable strobe. On that edge it captures the low byte of every read cycle that selects the socket.

By default the controller acts as a plain ROM: it drives flash A0-A7 from the captured byte and passes A8-A14 straight through. It drives flash A15-A19 from a five-bit block register, so a 1 MB flash appears to the host as a series of 32 KB windows. Command mode opens only after a fixed six-byte key. In command mode the host can select a new window, write the status register, or read back the status byte and then the version byte. After each command the controller returns to ROM emulation.

The `clk` input is the active ALE edge; the board inverts ALE so that the falling edge becomes a rising edge. The only reset is the synchronous power-on `rst`.

Top module: `sockcmd_ctrl`

## Requirements
- R1: On each qualifying read (`bus_sel` and `bus_rd` both high at the clock edge), flash address bits 7:0 become the captured `ad_lo` byte after that edge.
- R2: Clock edges without a qualifying read change nothing: the mode, the block register, the captured low byte and the key progress all hold.
- R3: From mode 3'b111, six consecutive qualifying reads with low bytes 0xB6, 0xF2, 0x34, 0xB0, 0x31, 0xBF switch `mode_state` to 3'b000. Any other six-byte series leaves the mode at 3'b111.
- R4: A qualifying read in mode 3'b111 whose byte does not match the next expected key byte clears the key progress. If that byte is 0xB6, matching resumes at the second key byte.
- R5: After reset, `mode_state` is 3'b111, the block register is 0, the status register is 0, `reg_rd_en` is 0 and the key progress is cleared.
- R6: Flash address bits 14:8 equal `hi_addr` at all times. Flash address bits 19:15 equal the block register.
- R7: In mode 3'b000, command byte 0x02 moves the mode to 3'b010. The next qualifying byte's bits 4:0 then load the block register.
- R8: In mode 3'b000, command byte 0x01 moves the mode to 3'b001. The next qualifying byte then loads the eight-bit status register.
- R9: In mode 3'b000, command byte 0x03 moves the mode to 3'b011. On the next qualifying read, `reg_rd_en` goes high with the status byte on `reg_rd_data`, and the mode moves to 3'b100. On the read after that, the version byte (parameter `VERSION`, default 0x46) is presented. On the next qualifying read, `reg_rd_en` falls.
- R10: Once a command completes, or when a command byte other than 0x01, 0x02 or 0x03 is received, the mode returns to 3'b111. An unknown command changes neither the block nor the status register.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Active ALE edge, inverted so it arrives as a rising edge |
| rst | input | 1 | Synchronous active-high power-on reset |
| bus_sel | input | 1 | Socket chip select, active high |
| bus_rd | input | 1 | Read cycle indicator, active high |
| ad_lo | input | 8 | Multiplexed low address/data byte |
| hi_addr | input | 7 | Socket address bits 14:8 |
| flash_addr | output | 20 | Flash address A0-A19 |
| mode_state | output | 3 | Current controller mode |
| reg_rd_en | output | 1 | High while the status or version byte is being presented |
| reg_rd_data | output | 8 | Status or version byte |

## Verification
The bench interleaves non-qualifying edges carrying wrong bytes inside a valid key. A design that sampled every edge would fail to unlock there and would also overwrite the low address. It sends a key that breaks at the fourth byte and then finishes the tail, which a matcher that did not clear its progress would wrongly accept. It also sends a repeated 0xB6 0xF2 prefix, which a matcher that did not restart on 0xB6 would reject. The status and version readback, a block byte with its upper bits set, an unknown command, and a reset in the middle of the key each catch a design that puts out the wrong byte, keeps stale upper bits, stays in command mode, or keeps partial key progress.

// File: rtl/sockcmd_pkg.sv
package sockcmd_pkg;

  typedef enum logic [2:0] {
    ST_NORM   = 3'b111,
    ST_CMD    = 3'b000,
    ST_LDSTAT = 3'b001,
    ST_LDBLK  = 3'b010,
    ST_RDSTAT = 3'b011,
    ST_RDVER  = 3'b100
  } mode_e;

  localparam int unsigned KEY_LEN = 6;
  localparam logic [8*KEY_LEN-1:0] KEY_SEQ = 48'hB6F2_34B0_31BF;

  localparam logic [7:0] CMD_SETSTAT = 8'h01;
  localparam logic [7:0] CMD_SETBLK  = 8'h02;
  localparam logic [7:0] CMD_READREG = 8'h03;

  function automatic logic [7:0] key_byte(int unsigned pos);
    return KEY_SEQ[8*(KEY_LEN-1-pos) +: 8];
  endfunction

endpackage

// File: rtl/sockcmd_keymatch.sv
module sockcmd_keymatch
  import sockcmd_pkg::*;
#(
  parameter int unsigned BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              qual,
  input  logic              armed,
  input  logic [BYTE_W-1:0] byte_i,
  output logic              hit_o
);
  localparam int unsigned IDX_W = $clog2(KEY_LEN);
  localparam int unsigned SLOTS = 1 << IDX_W;
  localparam logic [IDX_W-1:0] LAST = IDX_W'(KEY_LEN - 1);

  logic [IDX_W-1:0] idx_q;
  logic [SLOTS-1:0] eq;

  // one comparator per key position; unused slots never match
  for (genvar g = 0; g < SLOTS; g++) begin : g_cmp
    if (g < KEY_LEN) begin : g_live
      assign eq[g] = (byte_i == key_byte(g));
    end else begin : g_pad
      assign eq[g] = 1'b0;
    end
  end

  logic match_now;
  assign match_now = eq[idx_q];
  assign hit_o     = qual && armed && match_now && (idx_q == LAST);

  always_ff @(posedge clk) begin
    if (rst) begin
      idx_q <= '0;
    end else if (qual) begin
      if (!armed)               idx_q <= '0;
      else if (match_now)       idx_q <= (idx_q == LAST) ? '0 : idx_q + 1'b1;
      else if (eq[0])           idx_q <= IDX_W'(1);
      else                      idx_q <= '0;
    end
  end

  p_idx_bound_r3: assert property (@(posedge clk) disable iff (rst)
    idx_q <= LAST);

  p_restart_r4: assert property (@(posedge clk) disable iff (rst)
    (qual && armed && !match_now && byte_i == key_byte(0)) |=> idx_q == IDX_W'(1));

  p_hold_r2: assert property (@(posedge clk) disable iff (rst)
    !qual |=> $stable(idx_q));

endmodule

// File: rtl/sockcmd_fsm.sv
module sockcmd_fsm
  import sockcmd_pkg::*;
#(
  parameter int unsigned BYTE_W  = 8,
  parameter int unsigned BLK_W   = 5,
  parameter logic [7:0]  VERSION = 8'h46
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              qual,
  input  logic [BYTE_W-1:0] byte_i,
  input  logic              key_hit,
  output mode_e             mode_o,
  output logic [BLK_W-1:0]  blk_o,
  output logic              rd_en_o,
  output logic [BYTE_W-1:0] rd_data_o
);
  mode_e             mode_q;
  logic [BLK_W-1:0]  blk_q;
  logic [BYTE_W-1:0] stat_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      mode_q    <= ST_NORM;
      blk_q     <= '0;
      stat_q    <= '0;
      rd_en_o   <= 1'b0;
      rd_data_o <= '0;
    end else if (qual) begin
      rd_en_o <= 1'b0;
      unique case (mode_q)
        ST_NORM:   if (key_hit) mode_q <= ST_CMD;
        ST_CMD: begin
          if      (byte_i == CMD_SETBLK)  mode_q <= ST_LDBLK;
          else if (byte_i == CMD_SETSTAT) mode_q <= ST_LDSTAT;
          else if (byte_i == CMD_READREG) mode_q <= ST_RDSTAT;
          else                            mode_q <= ST_NORM;
        end
        ST_LDBLK: begin
          blk_q  <= byte_i[BLK_W-1:0];
          mode_q <= ST_NORM;
        end
        ST_LDSTAT: begin
          stat_q <= byte_i;
          mode_q <= ST_NORM;
        end
        ST_RDSTAT: begin
          rd_en_o   <= 1'b1;
          rd_data_o <= stat_q;
          mode_q    <= ST_RDVER;
        end
        ST_RDVER: begin
          rd_en_o   <= 1'b1;
          rd_data_o <= VERSION;
          mode_q    <= ST_NORM;
        end
        default: mode_q <= ST_NORM;
      endcase
    end
  end

  assign mode_o = mode_q;
  assign blk_o  = blk_q;

  p_reset_r5: assert property (@(posedge clk)
    rst |=> (mode_q == ST_NORM && blk_q == '0 && stat_q == '0 && !rd_en_o));

  p_cmd_needs_key_r3: assert property (@(posedge clk) disable iff (rst)
    (mode_q == ST_CMD && $past(mode_q) != ST_CMD) |-> $past(key_hit));

  p_ignore_r2: assert property (@(posedge clk) disable iff (rst)
    !qual |=> ($stable(mode_q) && $stable(blk_q) && $stable(stat_q)));

  p_blk_load_r7: assert property (@(posedge clk) disable iff (rst)
    (qual && mode_q == ST_LDBLK) |=> (blk_q == $past(byte_i[BLK_W-1:0]) && mode_q == ST_NORM));

  p_ver_r9: assert property (@(posedge clk) disable iff (rst)
    (qual && mode_q == ST_RDVER) |=> (rd_en_o && rd_data_o == VERSION));

  p_unknown_r10: assert property (@(posedge clk) disable iff (rst)
    (qual && mode_q == ST_CMD && byte_i > CMD_READREG) |=> (mode_q == ST_NORM && $stable(blk_q)));

endmodule

// File: rtl/sockcmd_addrdrv.sv
module sockcmd_addrdrv #(
  parameter int unsigned BYTE_W = 8,
  parameter int unsigned MID_W  = 7,
  parameter int unsigned BLK_W  = 5,
  localparam int unsigned ADDR_W = BYTE_W + MID_W + BLK_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              qual,
  input  logic [BYTE_W-1:0] byte_i,
  input  logic [MID_W-1:0]  mid_i,
  input  logic [BLK_W-1:0]  blk_i,
  output logic [ADDR_W-1:0] addr_o
);
  logic [BYTE_W-1:0] lo_q;

  always_ff @(posedge clk) begin
    if (rst)       lo_q <= '0;
    else if (qual) lo_q <= byte_i;
  end

  assign addr_o = {blk_i, mid_i, lo_q};

  p_lo_capture_r1: assert property (@(posedge clk) disable iff (rst)
    qual |=> addr_o[BYTE_W-1:0] == $past(byte_i));

  p_lo_hold_r2: assert property (@(posedge clk) disable iff (rst)
    !qual |=> $stable(lo_q));

endmodule

// File: rtl/sockcmd_ctrl.sv
module sockcmd_ctrl
  import sockcmd_pkg::*;
#(
  parameter int unsigned BYTE_W  = 8,
  parameter int unsigned MID_W   = 7,
  parameter int unsigned BLK_W   = 5,
  parameter logic [7:0]  VERSION = 8'h46,
  localparam int unsigned ADDR_W = BYTE_W + MID_W + BLK_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_sel,
  input  logic              bus_rd,
  input  logic [BYTE_W-1:0] ad_lo,
  input  logic [MID_W-1:0]  hi_addr,
  output logic [ADDR_W-1:0] flash_addr,
  output logic [2:0]        mode_state,
  output logic              reg_rd_en,
  output logic [BYTE_W-1:0] reg_rd_data
);
  logic             qual;
  logic             key_hit;
  mode_e            mode;
  logic [BLK_W-1:0] blk;

  assign qual = bus_sel && bus_rd;

  sockcmd_keymatch #(.BYTE_W(BYTE_W)) u_key (
    .clk    (clk),
    .rst    (rst),
    .qual   (qual),
    .armed  (mode == ST_NORM),
    .byte_i (ad_lo),
    .hit_o  (key_hit)
  );

  sockcmd_fsm #(.BYTE_W(BYTE_W), .BLK_W(BLK_W), .VERSION(VERSION)) u_fsm (
    .clk       (clk),
    .rst       (rst),
    .qual      (qual),
    .byte_i    (ad_lo),
    .key_hit   (key_hit),
    .mode_o    (mode),
    .blk_o     (blk),
    .rd_en_o   (reg_rd_en),
    .rd_data_o (reg_rd_data)
  );

  sockcmd_addrdrv #(.BYTE_W(BYTE_W), .MID_W(MID_W), .BLK_W(BLK_W)) u_addr (
    .clk    (clk),
    .rst    (rst),
    .qual   (qual),
    .byte_i (ad_lo),
    .mid_i  (hi_addr),
    .blk_i  (blk),
    .addr_o (flash_addr)
  );

  assign mode_state = mode;

  p_mid_pass_r6: assert property (@(posedge clk) disable iff (rst)
    flash_addr[BYTE_W +: MID_W] == hi_addr);

endmodule

// File: tb/tb_sockcmd_ctrl.sv
module tb_sockcmd_ctrl;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        bus_sel = 1'b0;
  logic        bus_rd = 1'b0;
  logic [7:0]  ad_lo = '0;
  logic [6:0]  hi_addr = '0;
  logic [19:0] flash_addr;
  logic [2:0]  mode_state;
  logic        reg_rd_en;
  logic [7:0]  reg_rd_data;

  int n_run = 0;
  int n_fail = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  sockcmd_ctrl dut (
    .clk(clk), .rst(rst), .bus_sel(bus_sel), .bus_rd(bus_rd), .ad_lo(ad_lo),
    .hi_addr(hi_addr), .flash_addr(flash_addr), .mode_state(mode_state),
    .reg_rd_en(reg_rd_en), .reg_rd_data(reg_rd_data)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic cyc(input bit sel, input bit rd, input logic [7:0] b);
    @(negedge clk);
    bus_sel = sel; bus_rd = rd; ad_lo = b;
    @(posedge clk);
    #1;
  endtask

  task automatic rd(input logic [7:0] b);
    cyc(1'b1, 1'b1, b);
  endtask

  task automatic send_key();
    rd(8'hB6); rd(8'hF2); rd(8'h34); rd(8'hB0); rd(8'h31); rd(8'hBF);
  endtask

  task automatic do_reset();
    @(negedge clk); rst = 1'b1; bus_sel = 0; bus_rd = 0;
    repeat (3) @(posedge clk);
    @(negedge clk); rst = 1'b0;
  endtask

  task automatic t_reset();
    do_reset();
    chk(mode_state == 3'b111, "R5 mode", mode_state, 3'b111);
    chk(flash_addr[19:15] == 0, "R5 block", flash_addr[19:15], 0);
    chk(reg_rd_en == 0, "R5 rd_en", reg_rd_en, 0);
  endtask

  task automatic t_addr();
    hi_addr = 7'h33;
    rd(8'h5A);
    chk(flash_addr[7:0] == 8'h5A, "R1 low byte", flash_addr[7:0], 8'h5A);
    chk(flash_addr[14:8] == 7'h33, "R6 pass-through", flash_addr[14:8], 7'h33);
    cyc(1'b0, 1'b1, 8'h11);
    chk(flash_addr[7:0] == 8'h5A, "R2 low byte hold sel", flash_addr[7:0], 8'h5A);
    cyc(1'b1, 1'b0, 8'h22);
    chk(flash_addr[7:0] == 8'h5A, "R2 low byte hold rd", flash_addr[7:0], 8'h5A);
  endtask

  task automatic t_key_gaps();
    rd(8'hB6); rd(8'hF2);
    cyc(1'b0, 1'b1, 8'h00);
    cyc(1'b1, 1'b0, 8'h77);
    rd(8'h34); rd(8'hB0); rd(8'h31);
    chk(mode_state == 3'b111, "R3 not yet unlocked", mode_state, 3'b111);
    rd(8'hBF);
    chk(mode_state == 3'b000, "R2 R3 unlock across ignored edges", mode_state, 3'b000);
    rd(8'h55);
    chk(mode_state == 3'b111, "R10 unknown cmd", mode_state, 3'b111);
  endtask

  task automatic t_key_break();
    rd(8'hB6); rd(8'hF2); rd(8'h34); rd(8'h00); rd(8'h31); rd(8'hBF);
    chk(mode_state == 3'b111, "R4 broken key rejected", mode_state, 3'b111);
  endtask

  task automatic t_key_restart();
    rd(8'hB6); rd(8'hF2); send_key();
    chk(mode_state == 3'b000, "R4 restart on 0xB6", mode_state, 3'b000);
    rd(8'hFF);
    chk(mode_state == 3'b111, "R10 exit", mode_state, 3'b111);
  endtask

  task automatic t_block();
    send_key();
    rd(8'h02);
    chk(mode_state == 3'b010, "R7 load-block mode", mode_state, 3'b010);
    rd(8'hF3);
    chk(flash_addr[19:15] == 5'h13, "R7 block bits", flash_addr[19:15], 5'h13);
    chk(mode_state == 3'b111, "R10 after block", mode_state, 3'b111);
    chk(flash_addr[7:0] == 8'hF3, "R1 low byte", flash_addr[7:0], 8'hF3);
    send_key(); rd(8'h09);
    chk(flash_addr[19:15] == 5'h13, "R10 unknown keeps block", flash_addr[19:15], 5'h13);
    chk(mode_state == 3'b111, "R10 unknown exits", mode_state, 3'b111);
  endtask

  task automatic t_status();
    send_key(); rd(8'h01);
    chk(mode_state == 3'b001, "R8 load-status mode", mode_state, 3'b001);
    rd(8'hA5);
    chk(mode_state == 3'b111, "R10 after status", mode_state, 3'b111);
    send_key(); rd(8'h03);
    chk(mode_state == 3'b011, "R9 readback mode", mode_state, 3'b011);
    chk(reg_rd_en == 0, "R9 not yet", reg_rd_en, 0);
    rd(8'h00);
    chk(reg_rd_en == 1 && reg_rd_data == 8'hA5, "R8 R9 status byte", reg_rd_data, 8'hA5);
    chk(mode_state == 3'b100, "R9 version mode", mode_state, 3'b100);
    rd(8'h00);
    chk(reg_rd_en == 1 && reg_rd_data == 8'h46, "R9 version byte", reg_rd_data, 8'h46);
    chk(mode_state == 3'b111, "R10 after readback", mode_state, 3'b111);
    rd(8'h00);
    chk(reg_rd_en == 0, "R9 rd_en falls", reg_rd_en, 0);
  endtask

  task automatic t_power_cycle();
    rd(8'hB6); rd(8'hF2); rd(8'h34);
    do_reset();
    chk(flash_addr[19:15] == 0, "R5 block cleared", flash_addr[19:15], 0);
    rd(8'hB0); rd(8'h31); rd(8'hBF);
    chk(mode_state == 3'b111, "R5 key progress cleared", mode_state, 3'b111);
    send_key(); rd(8'h03); rd(8'h00);
    chk(reg_rd_data == 8'h00, "R5 status cleared", reg_rd_data, 0);
  endtask

  initial begin
    t_reset();
    t_addr();
    t_key_gaps();
    t_key_break();
    t_key_restart();
    t_block();
    t_status();
    t_power_cycle();
    if (!done) begin
      done = 1;
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_run++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

endmodule